// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates the five interrupt sources of an 8-bit microcontroller core: two external request pins, two timer overflow events and one serial-port flag. Software configures it through a small register port holding an enable register (one bit per source plus a master enable), a priority register (one level bit per source) and a trigger register that makes each external pin edge- or level-sensitive.

Pending requests are copied into a poll snapshot only on the machine-cycle phase strobe. Among the enabled snapshot bits, the block picks one winner. A high-level request always beats a low-level one. Within a level the order is fixed. The block drives the winner's vector address together with an interrupt request. When the CPU takes the request, the block records the level now in service and pulses a one-hot acknowledge. It also clears the flags that hardware owns. A return pulse from the CPU closes the most recently opened level.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all three configuration registers read zero, `irq_req` is low, `irq_vec` is 0x0000 and `ack_src` is zero.
- R2: Register address 0 is the enable register: bits 4:0 enable the sources by index and bit 7 is the master enable. Bits 6:5 read zero and ignore writes. Address 1 holds the priority bits 4:0 (1 = high level), and bits 7:5 read zero. Address 2 holds the trigger bits: bit 0 is for external pin 0 and bit 1 for external pin 1, with 1 = edge and 0 = level. Its bits 7:2 read zero. Address 3 reads zero.
- R3: While the master enable is 0, `irq_req` stays low whatever the individual enables hold. Changing the master enable takes effect in the cycle after the write, with no new poll.
- R4: The source indices are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. The vector of index i is 0x0003 + 8*i.
- R5: When several requests of the same level are pending, the lowest index wins.
- R6: A pending high-level request wins over any pending low-level request.
- R7: While a low-level routine is in service, only a high-level request raises `irq_req`.
- R8: While a high-level routine is in service, `irq_req` stays low.
- R9: A `reti` pulse closes the high level if it is open, and otherwise closes the low level.
- R10: The poll snapshot changes only on `poll_stb`. A timer overflow that arrives in the same cycle as the strobe is seen only at the following strobe.
- R11: When `cpu_take` is high while `irq_req` is high, `ack_src` carries the winner as a one-hot value for exactly the next cycle. This take clears an edge-mode external flag and a timer flag. A level-mode external request and the serial flag are not cleared, so they request again at the next strobe if they are still active.
- R12: When a timer overflow arrives in the same cycle as the take that clears the flag of that timer, the overflow is kept pending.
- R13: In edge mode, a falling edge on an active-low external pin sets a flag that stays set after the pin returns high. In level mode, a request exists only while the pin, registered one cycle, is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses, one per timer |
| ser_flag | input | 1 | Serial port flag level, cleared by software elsewhere |
| poll_stb | input | 1 | Machine-cycle phase strobe that loads the poll snapshot |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cpu_take | input | 1 | CPU accepts the present request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the winner, zero when there is no request |
| ack_src | output | 5 | One-hot acknowledge of the source that was taken |

## Verification
Two events can fall in the same cycle: the take that clears a timer flag, and a fresh overflow of that same timer. The bench raises `tmr_ovf` in the very cycle in which `cpu_take` is high. It then closes the level with `reti` and polls again. The case passes only if the same vector is requested once more. A second coincidence is handled the same way: the strobe and an overflow arrive together, and the bench confirms that the request stays low until the following strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // number of interrupt sources and index width
    localparam int unsigned NSRC  = 5;
    localparam int unsigned SRC_W = $clog2(NSRC);
    // external pins and timers alternate: ext k -> 2k, timer k -> 2k+1
    localparam int unsigned NEXT  = 2;
    localparam int unsigned NTMR  = 2;
    localparam int unsigned SER_IDX = NSRC - 1;

    typedef enum logic [1:0] {
        RA_EN   = 2'd0,
        RA_PRI  = 2'd1,
        RA_TRIG = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic            gen;
        logic [NSRC-1:0] pri;
        logic [NEXT-1:0] edge_mode;
    } irq_cfg_t;

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output irq_cfg_t          cfg
);

    localparam int unsigned GEN_BIT = DATA_W - 1;

    irq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (reg_addr_e'(addr))
                RA_EN: begin
                    cfg_d.en  = wdata[NSRC-1:0];
                    cfg_d.gen = wdata[GEN_BIT];
                end
                RA_PRI:  cfg_d.pri       = wdata[NSRC-1:0];
                RA_TRIG: cfg_d.edge_mode = wdata[NEXT-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            RA_EN: begin
                rdata[NSRC-1:0] = cfg_q.en;
                rdata[GEN_BIT]  = cfg_q.gen;
            end
            RA_PRI:  rdata[NSRC-1:0] = cfg_q.pri;
            RA_TRIG: rdata[NEXT-1:0] = cfg_q.edge_mode;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata[GEN_BIT-1:NSRC];

    assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_EN) |=> (cfg_q.en == $past(wdata[NSRC-1:0]) && cfg_q.gen == $past(wdata[GEN_BIT])));

    assert_pri_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_PRI) |=> (cfg_q.pri == $past(wdata[NSRC-1:0])));

endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_pin_n,
    input  logic [NTMR-1:0]  tmr_ovf,
    input  logic             ser_flag,
    input  logic [NEXT-1:0]  edge_mode,
    input  logic             poll_stb,
    input  logic             clr_valid,
    input  logic [SRC_W-1:0] clr_idx,
    output logic [NSRC-1:0]  snap
);

    typedef struct packed {
        logic [NEXT-1:0] pin;
        logic [NEXT-1:0] eflag;
        logic [NTMR-1:0] tflag;
        logic [NSRC-1:0] snap;
    } flag_state_t;

    localparam flag_state_t FLAG_RST = '{pin: '1, eflag: '0, tflag: '0, snap: '0};

    flag_state_t st_d, st_q;
    logic [NSRC-1:0] raw;
    logic [NEXT-1:0] fall;

    always_comb begin
        fall = st_q.pin & ~ext_pin_n;
        raw  = '0;
        for (int k = 0; k < NEXT; k++) begin
            raw[2*k] = edge_mode[k] ? st_q.eflag[k] : ~st_q.pin[k];
        end
        for (int k = 0; k < NTMR; k++) begin
            raw[2*k+1] = st_q.tflag[k];
        end
        raw[SER_IDX] = ser_flag;
    end

    always_comb begin
        st_d     = st_q;
        st_d.pin = ext_pin_n;
        for (int k = 0; k < NEXT; k++) begin
            if (!edge_mode[k]) begin
                st_d.eflag[k] = 1'b0;
            end else begin
                if (clr_valid && clr_idx == SRC_W'(2*k)) st_d.eflag[k] = 1'b0;
                if (fall[k])                            st_d.eflag[k] = 1'b1;
            end
        end
        for (int k = 0; k < NTMR; k++) begin
            if (clr_valid && clr_idx == SRC_W'(2*k+1)) st_d.tflag[k] = 1'b0;
            if (tmr_ovf[k])                           st_d.tflag[k] = 1'b1;
        end
        if (poll_stb) st_d.snap = raw;
        if (clr_valid) begin
            for (int i = 0; i < NSRC; i++) begin
                if (clr_idx == SRC_W'(i)) st_d.snap[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_RST;
        else        st_q <= st_d;
    end

    assign snap = st_q.snap;

    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_stb && !clr_valid) |=> $stable(snap));

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf[0] |=> st_q.tflag[0]);

    assert_edge_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode[0] && st_q.eflag[0] && !(clr_valid && clr_idx == '0)) |=> (st_q.eflag[0] || !edge_mode[0]));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int unsigned N     = 5,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic       push_hi,
    input  logic       pop,
    output logic [1:0] active
);

    typedef struct packed {
        logic [1:0] act;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            if (st_q.act[1]) st_d.act[1] = 1'b0;
            else             st_d.act[0] = 1'b0;
        end
        if (push_valid) st_d.act[push_hi] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

    assert_no_push_in_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !st_q.act[1]);

    assert_lo_no_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_hi) |-> !st_q.act[0]);

    assert_pop_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_valid && st_q.act[1]) |=> (!st_q.act[1] && st_q.act[0] == $past(st_q.act[0])));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned VEC_W      = 16,
    parameter int unsigned VEC_BASE   = 3,
    parameter int unsigned VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ext_pin_n,
    input  logic [1:0]        tmr_ovf,
    input  logic              ser_flag,
    input  logic              poll_stb,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cpu_take,
    input  logic              reti,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [NSRC-1:0]   ack_src
);

    irq_cfg_t          cfg;
    logic [NSRC-1:0]   snap;
    logic [NSRC-1:0]   elig;
    logic [NSRC-1:0]   lvl_req [2];
    logic [1:0]        lvl_valid;
    logic [SRC_W-1:0]  lvl_idx [2];
    logic [1:0]        active;
    logic              win_valid;
    logic              win_hi;
    logic [SRC_W-1:0]  win_idx;
    logic              take;

    irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    irq_src_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin_n (ext_pin_n),
        .tmr_ovf   (tmr_ovf),
        .ser_flag  (ser_flag),
        .edge_mode (cfg.edge_mode),
        .poll_stb  (poll_stb),
        .clr_valid (take),
        .clr_idx   (win_idx),
        .snap      (snap)
    );

    assign elig       = snap & cfg.en & {NSRC{cfg.gen}};
    assign lvl_req[0] = elig & ~cfg.pri;
    assign lvl_req[1] = elig & cfg.pri;

    for (genvar g = 0; g < 2; g++) begin : g_level
        irq_pick #(.N(NSRC), .IDX_W(SRC_W)) u_pick (
            .req   (lvl_req[g]),
            .valid (lvl_valid[g]),
            .idx   (lvl_idx[g])
        );
    end

    always_comb begin
        win_valid = 1'b0;
        win_hi    = 1'b0;
        win_idx   = '0;
        if (!active[1] && lvl_valid[1]) begin
            win_valid = 1'b1;
            win_hi    = 1'b1;
            win_idx   = lvl_idx[1];
        end else if (!active[1] && !active[0] && lvl_valid[0]) begin
            win_valid = 1'b1;
            win_idx   = lvl_idx[0];
        end
    end

    assign take    = cpu_take && win_valid;
    assign irq_req = win_valid;
    assign irq_vec = win_valid ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STRIDE)) : '0;

    irq_level_stack u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (take),
        .push_hi    (win_hi),
        .pop        (reti),
        .active     (active)
    );

    logic [NSRC-1:0] ack_d, ack_q;

    always_comb begin
        ack_d = '0;
        if (take) ack_d[win_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign ack_src = ack_q;

    assert_master_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.gen |-> !irq_req);

    assert_hi_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active[1] |-> !irq_req);

    assert_lo_only_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active[0] && irq_req) |-> (elig & cfg.pri) != '0);

    assert_ack_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_src));

    assert_ack_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_src != '0) |-> $past(cpu_take && irq_req));

    assert_vec_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec < VEC_W'(VEC_BASE + NSRC * VEC_STRIDE)));

endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_flag = 1'b0;
    logic        poll_stb = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        cpu_take = 1'b0;
    logic        reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [4:0]  ack_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_arbiter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin_n (ext_pin_n),
        .tmr_ovf   (tmr_ovf),
        .ser_flag  (ser_flag),
        .poll_stb  (poll_stb),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_take  (cpu_take),
        .reti      (reti),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .ack_src   (ack_src)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_pin_n = 2'b11; tmr_ovf = 2'b00; ser_flag = 1'b0;
        poll_stb = 1'b0; reg_we = 1'b0; cpu_take = 1'b0; reti = 1'b0;
        reg_addr = 2'd0; reg_wdata = 8'd0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic poll();   poll_stb = 1'b1; tick(); poll_stb = 1'b0; endtask
    task automatic take();   cpu_take = 1'b1; tick(); cpu_take = 1'b0; endtask
    task automatic ret();    reti = 1'b1; tick(); reti = 1'b0; endtask
    task automatic ovf(input int k); tmr_ovf[k] = 1'b1; tick(); tmr_ovf = 2'b00; endtask
    task automatic ext_fall(input int k);
        ext_pin_n[k] = 1'b0; tick(); ext_pin_n[k] = 1'b1; tick();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1 irq_req", 32'(irq_req), 0);
        chk("R1 irq_vec", 32'(irq_vec), 0);
        chk("R1 ack_src", 32'(ack_src), 0);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), d);
            chk("R1 reg read", 32'(d), 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        do_reset();
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 enable reserved", 32'(d), 32'h9F);
        wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 priority", 32'(d), 32'h1F);
        wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 trigger", 32'(d), 32'h03);
        wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 empty address", 32'(d), 0);
        wr(2'd0, 8'h65); rd(2'd0, d); chk("R2 enable pattern", 32'(d), 32'h05);
    endtask

    task automatic t_vectors();
        for (int i = 0; i < 5; i++) begin
            do_reset();
            wr(2'd0, 8'h80 | 8'(1 << i));
            wr(2'd2, 8'h03);
            case (i)
                0: ext_fall(0);
                1: ovf(0);
                2: ext_fall(1);
                3: ovf(1);
                default: ser_flag = 1'b1;
            endcase
            tick();
            poll();
            chk("R4 request", 32'(irq_req), 1);
            chk("R4 vector", 32'(irq_vec), 32'(3 + 8 * i));
            take();
            chk("R11 ack onehot", 32'(ack_src), 32'(1 << i));
            tick();
            chk("R11 ack one cycle", 32'(ack_src), 0);
        end
    endtask

    task automatic t_master();
        do_reset();
        wr(2'd0, 8'h1F);
        ovf(0);
        poll();
        chk("R3 masked", 32'(irq_req), 0);
        wr(2'd0, 8'h9F);
        chk("R3 unmasked", 32'(irq_req), 1);
        chk("R3 vector", 32'(irq_vec), 32'h0B);
        wr(2'd0, 8'h1F);
        chk("R3 remasked", 32'(irq_req), 0);
    endtask

    task automatic t_order();
        logic [15:0] expv [5] = '{16'h03, 16'h0B, 16'h13, 16'h1B, 16'h23};
        do_reset();
        wr(2'd0, 8'h9F);
        wr(2'd2, 8'h03);
        ext_pin_n = 2'b00; tmr_ovf = 2'b11; ser_flag = 1'b1;
        tick();
        ext_pin_n = 2'b11; tmr_ovf = 2'b00;
        tick();
        poll();
        ser_flag = 1'b0;
        for (int n = 0; n < 5; n++) begin
            chk("R5 order vector", 32'(irq_vec), 32'(expv[n]));
            take();
            chk("R7 low blocks low", 32'(irq_req), 0);
            ret();
        end
        chk("R5 all served", 32'(irq_req), 0);
    endtask

    task automatic t_hi_lo();
        do_reset();
        wr(2'd0, 8'h9F);
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h03);
        ser_flag = 1'b1;
        ext_fall(0);
        poll();
        chk("R6 high wins", 32'(irq_vec), 32'h23);
        take();
        chk("R6 ack serial", 32'(ack_src), 32'h10);
        ser_flag = 1'b0;
    endtask

    task automatic t_nesting();
        do_reset();
        wr(2'd0, 8'h9F);
        wr(2'd1, 8'h08);
        wr(2'd2, 8'h03);
        ext_fall(0);
        poll();
        take();
        ovf(0);
        poll();
        chk("R7 low cannot preempt", 32'(irq_req), 0);
        ovf(1);
        poll();
        chk("R7 high preempts", 32'(irq_req), 1);
        chk("R7 high vector", 32'(irq_vec), 32'h1B);
        take();
        chk("R7 ack timer1", 32'(ack_src), 32'h08);
        wr(2'd1, 8'h0C);
        ext_fall(1);
        poll();
        chk("R8 high not preempted", 32'(irq_req), 0);
        ret();
        chk("R9 high closed first", 32'(irq_vec), 32'h13);
        take();
        ret();
        chk("R9 low still open", 32'(irq_req), 0);
        ret();
        chk("R9 low closed", 32'(irq_vec), 32'h0B);
    endtask

    task automatic t_sampling();
        do_reset();
        wr(2'd0, 8'h82);
        ovf(0);
        chk("R10 no strobe", 32'(irq_req), 0);
        take();
        do_reset();
        wr(2'd0, 8'h82);
        tmr_ovf[0] = 1'b1; poll_stb = 1'b1;
        tick();
        tmr_ovf = 2'b00; poll_stb = 1'b0;
        chk("R10 same cycle unseen", 32'(irq_req), 0);
        poll();
        chk("R10 next strobe", 32'(irq_req), 1);
    endtask

    task automatic t_clear();
        do_reset();
        wr(2'd0, 8'h9F);
        ovf(0);
        poll();
        take();
        ret();
        poll();
        chk("R11 timer cleared", 32'(irq_req), 0);
        ser_flag = 1'b1;
        tick();
        poll();
        take();
        ret();
        poll();
        chk("R11 serial kept", 32'(irq_vec), 32'h23);
        ser_flag = 1'b0;
        tick();
        poll();
        chk("R11 serial gone", 32'(irq_req), 0);
        ext_pin_n[0] = 1'b0;
        tick();
        poll();
        take();
        ret();
        poll();
        chk("R11 level kept", 32'(irq_vec), 32'h03);
        ext_pin_n[0] = 1'b1;
        tick();
        poll();
        chk("R13 level released", 32'(irq_req), 0);
    endtask

    task automatic t_coincide();
        do_reset();
        wr(2'd0, 8'h9F);
        ovf(0);
        poll();
        cpu_take = 1'b1; tmr_ovf[0] = 1'b1;
        tick();
        cpu_take = 1'b0; tmr_ovf = 2'b00;
        chk("R12 ack", 32'(ack_src), 32'h02);
        ret();
        poll();
        chk("R12 overflow kept", 32'(irq_vec), 32'h0B);
    endtask

    task automatic t_edge();
        do_reset();
        wr(2'd0, 8'h85);
        wr(2'd2, 8'h01);
        ext_fall(0);
        tick();
        poll();
        chk("R13 edge held", 32'(irq_vec), 32'h03);
        take();
        ret();
        ext_fall(1);
        tick();
        poll();
        chk("R13 short level pulse lost", 32'(irq_req), 0);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_vectors();
        t_master();
        t_order();
        t_hi_lo();
        t_nesting();
        t_sampling();
        t_clear();
        t_coincide();
        t_edge();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule